// File: doc/BRIEF.md
# Low-power real-time counter with seconds alarm

The block keeps wall-clock time for a chip that spends most of its life asleep. A counter with `FRAC_W` sub-second bits and 32 bits of whole seconds advances once per rising edge of a slow reference clock (nominally 32.768 kHz). The slow clock is brought into the bus clock domain through a synchroniser, and the counter advances on the detected edges. Software reaches the block through a simple 32-bit register port: it can enable the counter, load it while stopped, program a seconds alarm, and enable an interrupt and a wakeup request.

Changes to control bits do not take effect at once. They pass through a pipeline that advances only on slow-clock edges, and the control register reads back the value already in effect, so software polls until the value matches what it wrote. Counter reads come from a snapshot taken at each slow edge. The two words are therefore coherent with each other, and two reads in a row agree unless a slow edge falls between them, in which case software reads again.

Top module: `lp_rtc`

## Requirements
- R1: After reset the counter, the snapshot, the control state, the alarm value, the alarm flag, `irq` and `wake` are all zero, and every register reads as zero.
- R2: A read request returns its data on `bus_rdata` in the following cycle. The register offsets are: control 0x04, status 0x18, counter high word 0x1C, counter low word 0x20, alarm 0x24, glitch-detector init 0x30. Any other offset reads as zero.
- R3: The control register holds the counter enable in bit 0, the alarm enable in bit 1 and the wakeup enable in bit 3. A written value takes effect, and shows in read-back, only after it has passed `SYNC_STAGES` detected slow-clock rising edges. Read-back always shows the value currently in effect.
- R4: While the effective counter enable is 1, the counter grows by one on each detected slow-clock rising edge, wrapping modulo 2^(32+FRAC_W). Bits 31:0 read at 0x20, and bits 32+FRAC_W-1:32 read in the low bits of 0x1C with the upper bits zero. Seconds are the counter bits above `FRAC_W`.
- R5: A write to either counter word loads that word only while the effective counter enable is 0. While the counter is enabled, such writes are ignored.
- R6: Counter reads return a snapshot of the counter captured at the most recent detected slow edge. The snapshot holds still between edges, so back-to-back reads within one slow period return the same value.
- R7: The alarm register holds a 32-bit seconds value and reads back what was written. The alarm flag (status bit 0) is set in every cycle in which the effective alarm enable is 1 and the seconds equal the alarm value.
- R8: The alarm flag stays set until software writes status with bit 0 at 1. Writing 0 leaves it unchanged. If a match occurs in the same cycle as the clear, the flag stays set.
- R9: `irq` equals the alarm flag ANDed with the effective alarm enable. `wake` equals `irq` ANDed with the effective wakeup enable.
- R10: Register 0x30 reads 1 in bit 0 exactly when the last value written to it was 0x41736166, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow reference clock, sampled in the bus domain |
| bus_req | input | 1 | Register access request for one cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Wakeup request |

## Verification
The bench builds the block with `FRAC_W` = 3 and `SYNC_STAGES` = 3, and runs the slow clock at one-eighth of the bus clock. With these values a new second arrives every eight slow edges. That brings an alarm match, the sticky flag after the seconds have moved on, and the carry of the low word into the high word within a few hundred cycles. Loading the counter just below a 32-bit boundary exercises the high-word split. Reading control right after a write shows the old value still in effect, and reading it again once the pipeline has advanced shows the new one.

// File: rtl/lp_rtc.sv
module lp_rtc #(
  parameter int FRAC_W      = 15,
  parameter int SYNC_STAGES = 3,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              wake
);

  localparam int CNT_W = 32 + FRAC_W;
  localparam int HI_W  = CNT_W - 32;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_CNTHI = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFS_CNTLO = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFS_ALARM = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] OFS_GLTCH = ADDR_W'(8'h30);
  localparam logic [31:0] GLITCH_KEY = 32'h4173_6166;

  logic [2:0] slow_sync;
  logic       tick;
  logic [2:0] ctrl_req;
  logic [SYNC_STAGES-1:0][2:0] ctrl_pipe;
  logic [2:0] ctrl_eff;
  logic       cnt_en, alm_en, wk_en;
  logic [CNT_W-1:0] cnt, snap;
  logic [31:0] alarm, seconds, rd_mux;
  logic       flag, hit, glitch_ok;
  logic       wr, rd, stat_clr;

  assign wr       = bus_req & bus_we;
  assign rd       = bus_req & ~bus_we;
  assign tick     = slow_sync[1] & ~slow_sync[2];
  assign ctrl_eff = ctrl_pipe[SYNC_STAGES-1];
  assign cnt_en   = ctrl_eff[0];
  assign alm_en   = ctrl_eff[1];
  assign wk_en    = ctrl_eff[2];
  assign seconds  = cnt[CNT_W-1:FRAC_W];
  assign hit      = alm_en && (seconds == alarm);
  assign stat_clr = wr && (bus_addr == OFS_STAT) && bus_wdata[0];
  assign irq      = flag & alm_en;
  assign wake     = irq & wk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slow_sync <= '0;
    else        slow_sync <= {slow_sync[1:0], slow_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_req  <= '0;
      ctrl_pipe <= '0;
    end else begin
      if (wr && bus_addr == OFS_CTRL)
        ctrl_req <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
      if (tick) begin
        ctrl_pipe[0] <= ctrl_req;
        for (int i = 1; i < SYNC_STAGES; i++)
          ctrl_pipe[i] <= ctrl_pipe[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      snap <= '0;
    end else begin
      if (wr && !cnt_en && bus_addr == OFS_CNTLO)
        cnt[31:0] <= bus_wdata;
      else if (wr && !cnt_en && bus_addr == OFS_CNTHI)
        cnt[CNT_W-1:32] <= bus_wdata[HI_W-1:0];
      else if (tick && cnt_en)
        cnt <= cnt + 1'b1;
      if (tick)
        snap <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm     <= '0;
      flag      <= 1'b0;
      glitch_ok <= 1'b0;
    end else begin
      if (wr && bus_addr == OFS_ALARM) alarm <= bus_wdata;
      if (wr && bus_addr == OFS_GLTCH) glitch_ok <= (bus_wdata == GLITCH_KEY);
      flag <= (flag & ~stat_clr) | hit;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL:  rd_mux = {28'd0, wk_en, 1'b0, alm_en, cnt_en};
      OFS_STAT:  rd_mux = {31'd0, flag};
      OFS_CNTHI: rd_mux = {{(32-HI_W){1'b0}}, snap[CNT_W-1:32]};
      OFS_CNTLO: rd_mux = snap[31:0];
      OFS_ALARM: rd_mux = alarm;
      OFS_GLTCH: rd_mux = {31'd0, glitch_ok};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

endmodule

module lp_rtc_chk #(
  parameter int CNT_W = 47
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_en,
  input logic [2:0]       ctrl_eff,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] snap,
  input logic             flag,
  input logic             stat_clr,
  input logic             irq,
  input logic             wake
);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_en) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r5_frozen_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !tick) |=> $stable(cnt));

  a_r3_ctrl_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ctrl_eff));

  a_r6_snap_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(snap));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !stat_clr) |=> flag);

  a_r9_wake_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

endmodule

bind lp_rtc lp_rtc_chk #(.CNT_W(CNT_W)) i_lp_rtc_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_en(cnt_en),
  .ctrl_eff(ctrl_eff), .cnt(cnt), .snap(snap), .flag(flag),
  .stat_clr(stat_clr), .irq(irq), .wake(wake)
);

// File: tb/test_lp_rtc.sv
`timescale 1ns/1ps
module test_lp_rtc;
  localparam int FRAC_W = 3;
  localparam int STAGES = 3;
  localparam int CW     = 32 + FRAC_W;
  localparam logic [63:0] CMASK = (64'd1 << CW) - 1;

  logic clk = 0, rst_n = 0, slow_clk = 0;
  logic bus_req = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq, wake;

  int checks = 0, failures = 0;
  string cur_tag = "R1";
  bit done = 0;

  lp_rtc #(.FRAC_W(FRAC_W), .SYNC_STAGES(STAGES), .ADDR_W(8)) i_lp_rtc (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake));

  always #2.5 clk = ~clk;

  initial forever begin
    repeat (4) @(negedge clk);
    slow_clk = ~slow_clk;
  end

  // reference model
  int seen[$];
  int pipe[$];
  int req_m;
  logic [63:0] cnt_m, snap_m;
  logic [31:0] alarm_m, rdata_m;
  bit flag_m, glitch_m, irq_m, wake_m, rd_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      seen = '{0, 0, 0};
      pipe = {};
      for (int i = 0; i < STAGES; i++) pipe.push_back(0);
      req_m = 0; cnt_m = 0; snap_m = 0; alarm_m = 0; rdata_m = 0;
      flag_m = 0; glitch_m = 0; irq_m = 0; wake_m = 0; rd_pend = 0;
    end else begin
      bit tk, en, al, wk, match, wr, rd;
      int eff;
      logic [63:0] c_old;
      logic [31:0] a_old;
      tk = (seen[1] == 1) && (seen[2] == 0);
      eff = pipe[STAGES-1];
      en = eff[0]; al = eff[1]; wk = eff[3];
      c_old = cnt_m; a_old = alarm_m;
      wr = bus_req && bus_we;
      rd = bus_req && !bus_we;
      match = al && (((c_old >> FRAC_W) & 64'hFFFF_FFFF) == {32'd0, a_old});
      rd_pend = rd;
      if (rd) begin
        case (bus_addr)
          8'h04: rdata_m = eff & 32'hB;
          8'h18: rdata_m = {31'd0, flag_m};
          8'h1C: rdata_m = snap_m[63:32];
          8'h20: rdata_m = snap_m[31:0];
          8'h24: rdata_m = alarm_m;
          8'h30: rdata_m = {31'd0, glitch_m};
          default: rdata_m = 0;
        endcase
      end
      if (wr && !en && bus_addr == 8'h20) cnt_m = {c_old[63:32], bus_wdata};
      else if (wr && !en && bus_addr == 8'h1C)
        cnt_m = ({32'd0, bus_wdata} & (CMASK >> 32)) << 32 | (c_old & 64'hFFFF_FFFF);
      else if (tk && en) cnt_m = (c_old + 1) & CMASK;
      if (tk) begin
        snap_m = c_old;
        pipe.push_front(req_m);
        void'(pipe.pop_back());
      end
      if (wr && bus_addr == 8'h04) req_m = int'(bus_wdata & 32'hB);
      if (wr && bus_addr == 8'h24) alarm_m = bus_wdata;
      if (wr && bus_addr == 8'h30) glitch_m = (bus_wdata == 32'h4173_6166);
      flag_m = (flag_m && !(wr && bus_addr == 8'h18 && bus_wdata[0])) || match;
      seen.push_front(int'(slow_clk));
      void'(seen.pop_back());
      eff = pipe[STAGES-1];
      irq_m = flag_m && eff[1];
      wake_m = irq_m && eff[3];
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9", "irq", {31'd0, irq}, {31'd0, irq_m});
      chk("R9", "wake", {31'd0, wake}, {31'd0, wake_m});
      if (rd_pend) chk(cur_tag, "rdata", bus_rdata, rdata_m);
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd_reg(logic [7:0] a);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1;
    // R1: reset state at the ports
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    chk("R1", "wake after reset", {31'd0, wake}, 32'd0);
    cur_tag = "R1";
    rd_reg(8'h04); rd_reg(8'h18); rd_reg(8'h20); rd_reg(8'h1C); rd_reg(8'h24);
    // R2: unmapped offset and read latency
    cur_tag = "R2";
    rd_reg(8'h08); rd_reg(8'h3C);
    // R10: glitch-detector init word
    cur_tag = "R10";
    wr_reg(8'h30, 32'h4173_6166); rd_reg(8'h30);
    wr_reg(8'h30, 32'h4173_6167); rd_reg(8'h30);
    wr_reg(8'h30, 32'h4173_6166); rd_reg(8'h30);
    // R5: load while stopped
    cur_tag = "R5";
    wr_reg(8'h1C, 32'h0);
    wr_reg(8'h20, (32'd10 << FRAC_W) | 32'd5);
    idle(20);
    rd_reg(8'h20);
    // R3: enable is delayed by the synchroniser
    cur_tag = "R3";
    wr_reg(8'h04, 32'h1);
    rd_reg(8'h04);
    idle(40);
    rd_reg(8'h04);
    // R5: writes ignored while running
    cur_tag = "R5";
    wr_reg(8'h20, 32'h0);
    wr_reg(8'h1C, 32'h7);
    idle(10);
    rd_reg(8'h20); rd_reg(8'h1C);
    // R6: back-to-back reads agree
    cur_tag = "R6";
    rd_reg(8'h20); rd_reg(8'h20);
    // R7: alarm read-back and match
    cur_tag = "R7";
    wr_reg(8'h24, 32'd12);
    rd_reg(8'h24);
    wr_reg(8'h04, 32'hB);
    idle(300);
    rd_reg(8'h18);
    // R8: write 0 keeps, write 1 clears
    cur_tag = "R8";
    wr_reg(8'h18, 32'h0);
    rd_reg(8'h18);
    wr_reg(8'h18, 32'h1);
    rd_reg(8'h18);
    // R4: carry into the high word, alarm without wakeup (R9)
    cur_tag = "R4";
    wr_reg(8'h04, 32'h0);
    idle(60);
    wr_reg(8'h1C, 32'h1);
    wr_reg(8'h20, 32'hFFFF_FFF8);
    wr_reg(8'h24, 32'h4000_0000);
    idle(20);
    rd_reg(8'h1C); rd_reg(8'h20);
    wr_reg(8'h04, 32'h3);
    idle(200);
    rd_reg(8'h1C); rd_reg(8'h20);
    cur_tag = "R8";
    rd_reg(8'h18);
    wr_reg(8'h18, 32'h1);
    rd_reg(8'h18);
    cur_tag = "R3";
    wr_reg(8'h04, 32'h0);
    idle(60);
    rd_reg(8'h04);
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule